// File: doc/BRIEF.md
# Integer Arithmetic/Logic Unit

A combinational arithmetic/logic unit for the execute stage of a simple load/store integer pipeline. Two operands and a 4-bit operation code go in. The same cycle yields a result word, a zero flag and a signed overflow flag. A single shared adder chain serves addition, subtraction and both compare operations. Subtraction feeds the inverted second operand into the chain and sets the carry into bit 0.

Branch-on-equal logic uses the zero flag after a subtract. Immediate extension, shifting, multiply and divide are handled elsewhere in the datapath. The overflow flag is meant to raise a trap for the signed add and subtract codes, so every other code holds it low.

Top module: `alu_core`

## Requirements
- R1: Codes 0010 (signed add) and 0011 (unsigned add) give `result` = A + B modulo 2^WIDTH.
- R2: Codes 0110 (signed subtract) and 1000 (unsigned subtract) give `result` = A − B modulo 2^WIDTH.
- R3: For codes 0010 and 0110, `overflow` is 1 exactly when the two's-complement result of the add or subtract falls outside the signed range of WIDTH bits.
- R4: For every code other than 0010 and 0110, `overflow` is 0.
- R5: Bitwise codes: 0000 gives A AND B, 0001 gives A OR B, 0100 gives A XOR B, 0101 gives NOT(A OR B).
- R6: Code 0111 (signed less-than) sets result bit 0 to 1 when A < B as two's-complement numbers and clears all other bits. The answer stays correct when A − B overflows.
- R7: Code 1001 (unsigned less-than) sets result bit 0 to 1 when A < B as unsigned numbers and clears all other bits.
- R8: `zero` is 1 exactly when every bit of `result` is 0. Under code 0110, `zero` is therefore 1 exactly when A equals B.
- R9: The unused codes 1010 through 1111 give `result` = 0 and `overflow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add/subtract codes |

## Verification
The bench builds two copies of the unit. One copy uses the default WIDTH of 32. It receives directed corner cases at the signed extremes, including a compare whose internal subtraction overflows, followed by seeded random traffic over all sixteen codes. The second copy uses WIDTH = 4. At that width, every operand pair under every code fits in a few thousand cycles. This exhausts every carry, overflow and compare boundary that the 32-bit copy can reach only by sampling.

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;
  localparam logic [3:0] OP_AND  = 4'b0000;
  localparam logic [3:0] OP_OR   = 4'b0001;
  localparam logic [3:0] OP_ADD  = 4'b0010;
  localparam logic [3:0] OP_ADDU = 4'b0011;
  localparam logic [3:0] OP_XOR  = 4'b0100;
  localparam logic [3:0] OP_NOR  = 4'b0101;
  localparam logic [3:0] OP_SUB  = 4'b0110;
  localparam logic [3:0] OP_SLT  = 4'b0111;
  localparam logic [3:0] OP_SUBU = 4'b1000;
  localparam logic [3:0] OP_SLTU = 4'b1001;

  logic             subtract, signed_arith;
  logic [WIDTH-1:0] b_eff, sum;
  logic             carry_out, carry_msb, ovf_raw, lt_signed, lt_unsigned;

  assign subtract     = (op_sel == OP_SUB) || (op_sel == OP_SUBU) ||
                        (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign signed_arith = (op_sel == OP_ADD) || (op_sel == OP_SUB);

  assign b_eff = subtract ? ~opnd_b : opnd_b;
  assign {carry_out, sum} = {1'b0, opnd_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};

  assign carry_msb   = opnd_a[MSB] ^ b_eff[MSB] ^ sum[MSB];
  assign ovf_raw     = carry_msb ^ carry_out;
  assign lt_signed   = sum[MSB] ^ ovf_raw;
  assign lt_unsigned = ~carry_out;

  always_comb begin
    case (op_sel)
      OP_AND:                   result = opnd_a & opnd_b;
      OP_OR:                    result = opnd_a | opnd_b;
      OP_XOR:                   result = opnd_a ^ opnd_b;
      OP_NOR:                   result = ~(opnd_a | opnd_b);
      OP_ADD, OP_ADDU,
      OP_SUB, OP_SUBU:          result = sum;
      OP_SLT:                   result = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU:                  result = {{(WIDTH-1){1'b0}}, lt_unsigned};
      default:                  result = '0;
    endcase
  end

  assign overflow = signed_arith & ovf_raw;
  assign zero     = ~|result;

  always_comb begin
    if (!$isunknown({op_sel, opnd_a, opnd_b})) begin
      assert_no_overflow_R4: assert (signed_arith || !overflow)
        else $error("overflow raised on a code without trap");
      assert_add_ovf_signs_R3: assert (!(overflow && op_sel == OP_ADD) ||
          (opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB]))
        else $error("add overflow without sign mismatch");
      assert_sub_zero_equal_R8: assert (op_sel != OP_SUB || (zero == (opnd_a == opnd_b)))
        else $error("zero flag disagrees with operand equality");
      assert_slt_signed_R6: assert (op_sel != OP_SLT ||
          result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))})
        else $error("signed compare wrong");
      assert_sltu_unsigned_R7: assert (op_sel != OP_SLTU ||
          result == {{(WIDTH-1){1'b0}}, (opnd_a < opnd_b)})
        else $error("unsigned compare wrong");
      assert_and_subset_R5: assert (op_sel != OP_AND || (result & ~opnd_a & ~opnd_b) == '0)
        else $error("and result outside operands");
    end
  end
endmodule

// File: tb/test_alu_core.sv
module test_alu_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0]  op32, op4;
  logic [31:0] a32, b32, r32;
  logic [3:0]  a4, b4, r4;
  logic        z32, v32, z4, v4;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  alu_core #(.WIDTH(32)) i_alu_core (
    .op_sel(op32), .opnd_a(a32), .opnd_b(b32),
    .result(r32), .zero(z32), .overflow(v32));

  alu_core #(.WIDTH(4)) i_alu_core_w4 (
    .op_sel(op4), .opnd_a(a4), .opnd_b(b4),
    .result(r4), .zero(z4), .overflow(v4));

  function automatic logic [64:0] ref_alu(int w, logic [3:0] op,
                                          longint unsigned a, longint unsigned b);
    longint unsigned mask, r;
    longint sa, sb, hi, lo, full;
    logic v;
    mask = (longint'(1) << w) - 1;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -hi - 1;
    sa = a[w-1] ? longint'(a) - longint'(mask) - 1 : longint'(a);
    sb = b[w-1] ? longint'(b) - longint'(mask) - 1 : longint'(b);
    v = 1'b0;
    r = 0;
    case (op)
      4'd0: r = a & b;
      4'd1: r = a | b;
      4'd2, 4'd3: begin
        r = a + b; full = sa + sb;
        v = (op == 4'd2) && (full > hi || full < lo);
      end
      4'd4: r = a ^ b;
      4'd5: r = ~(a | b);
      4'd6, 4'd8: begin
        r = a - b; full = sa - sb;
        v = (op == 4'd6) && (full > hi || full < lo);
      end
      4'd7: r = (sa < sb) ? 1 : 0;
      4'd9: r = (a < b) ? 1 : 0;
      default: r = 0;
    endcase
    return {v, r & mask};
  endfunction

  function automatic string res_tag(logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd4, 4'd5: return "R5";
      4'd2, 4'd3:             return "R1";
      4'd6, 4'd8:             return "R2";
      4'd7:                   return "R6";
      4'd9:                   return "R7";
      default:                return "R9";
    endcase
  endfunction

  task automatic check(string tag, longint unsigned got, longint unsigned exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic verify(int w, logic [3:0] op, longint unsigned a, longint unsigned b);
    logic [64:0] e;
    longint unsigned got_r;
    logic got_z, got_v;
    e = ref_alu(w, op, a, b);
    @(negedge clk);
    if (w == 32) begin op32 = op; a32 = a[31:0]; b32 = b[31:0]; end
    else begin op4 = op; a4 = a[3:0]; b4 = b[3:0]; end
    #1;
    if (w == 32) begin got_r = r32; got_z = z32; got_v = v32; end
    else begin got_r = r4; got_z = z4; got_v = v4; end
    check(res_tag(op), got_r, e[63:0]);
    check((op == 4'd2 || op == 4'd6) ? "R3" : "R4", got_v, e[64]);
    check("R8", got_z, e[63:0] == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    op32 = 4'd0; a32 = '0; b32 = '0;
    op4 = 4'd0; a4 = '0; b4 = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R8", z32, 1'b1);
    check("R5", r32, 0);

    verify(32, 4'd2, 32'h7fffffff, 32'h1);          // R3 positive wrap
    verify(32, 4'd2, 32'h80000000, 32'hffffffff);   // R3 negative wrap
    verify(32, 4'd3, 32'h7fffffff, 32'h1);          // R4 unsigned add silent
    verify(32, 4'd6, 32'h80000000, 32'h1);          // R3 subtract wrap
    verify(32, 4'd6, 32'h7fffffff, 32'hffffffff);   // R3 subtract wrap
    verify(32, 4'd8, 32'h0, 32'h1);                 // R2 R4 unsigned borrow
    verify(32, 4'd7, 32'h80000000, 32'h1);          // R6 overflowing compare
    verify(32, 4'd7, 32'h7fffffff, 32'hffffffff);   // R6 overflowing compare
    verify(32, 4'd7, 32'h5, 32'h5);                 // R6 equal
    verify(32, 4'd9, 32'h0, 32'hffffffff);          // R7
    verify(32, 4'd9, 32'hffffffff, 32'h0);          // R7
    verify(32, 4'd6, 32'hdeadbeef, 32'hdeadbeef);   // R8 equal operands
    verify(32, 4'd5, 32'h0, 32'h0);                 // R5 nor
    verify(32, 4'd12, 32'hffffffff, 32'h1);         // R9 unused code

    for (int i = 0; i < 3000; i++)
      verify(32, 4'($urandom_range(15)), $urandom, $urandom);

    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          verify(4, 4'(op), longint'(a), longint'(b));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule